// File: doc/BRIEF.md
# Type-C Port Controller Alert and Receive Buffer Core

This block is the status core of a Type-C port controller. It keeps a 16-bit alert register with a matching 16-bit enable mask, and drives a single interrupt line towards the port manager. Incoming messages land in a small circular store. The store holds two retrievable messages and one scratch slot that the receive path fills while a message is still arriving. The port manager reads the oldest message through header, byte-count and data registers. Writing a one to the receive-status alert bit releases that message.

The receive path, the transmit path and the CC sampler report events on dedicated strobes. A synchronous register port with single-cycle read latency stands in for the host bus. After reset the block is uninitialized and ignores every register write. An initialization strobe loads the masks, raises the power-status alert and opens the register port.

Top module: `pdc_alert_core`

## Requirements
- R1: Every event sets its alert bit whatever the mask. The alert bits are: 0 CC status, 1 power status, 2 receive status, 3 received hard reset, 4 transmit failed, 5 transmit discarded, 6 transmit success. The interrupt rises only when an event sets a bit whose mask bit is one.
- R2: A write to the alert register (address 0x00) clears exactly the bits written as one and leaves the others. An event in the same cycle wins over the clear.
- R3: The interrupt stays asserted while any alert bit is set. It drops once all alert bits are zero.
- R4: Clearing bit 2 while messages are stored releases the oldest message. Bit 2 stays set if a message is still stored afterwards.
- R5: A good message is kept only when fewer than two messages are stored. A kept message is also acknowledged (ack_req pulses with ack_id = header bits 11:9) and raises bit 2. Otherwise the message is discarded, with no acknowledgement and no alert.
- R6: A received hard reset (rx_kind 1) sets bit 3 whatever the store occupancy. A good message is rx_kind 0.
- R7: A transmit report with tx_res 0 sets bit 6. A report with tx_res 1 (no GoodCRC) sets bit 4. Any other value sets bit 5.
- R8: The byte-count register (0x06) reads 3 + 4·N, where N is header bits 14:12 of the oldest stored message. The header register (0x07) returns that header.
- R9: While power-status bit 0 (uninitialized, register 0x02) is set, all writes are ignored. The initialization strobe clears that bit, sets the alert mask (0x01) to 0xFFFF and the power mask (0x03) to 0x00FF, and raises alert bit 1.
- R10: Writing a new pull value to 0x04 forces both CC status fields (0x05: bits 1:0 line 1, bits 3:2 line 2) to open (0) without an alert. A later sample that differs from the stored status sets bit 0. Writing the current pull value changes nothing.
- R11: Read data and its valid flag appear exactly one cycle after a read strobe.
- R12: Data registers 0x10 to 0x1D return the oldest message's data objects. The object index is address bits 3:1 and address bit 0 selects the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_go | input | 1 | Initialization strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| rx_word_we | input | 1 | Write one data object into the scratch slot |
| rx_word_idx | input | 3 | Data object index |
| rx_word | input | 32 | Data object value |
| rx_end | input | 1 | End of a received frame |
| rx_kind | input | 2 | 0 good, 1 hard reset, else bad |
| rx_hdr | input | 16 | Header of the received message |
| ack_req | output | 1 | Request to send an acknowledgement |
| ack_id | output | 3 | Message id to acknowledge |
| tx_done | input | 1 | Transmit outcome strobe |
| tx_res | input | 2 | Transmit outcome code |
| cc_meas_vld | input | 1 | New CC sample strobe |
| cc1_meas | input | 2 | Sampled status of CC line 1 |
| cc2_meas | input | 2 | Sampled status of CC line 2 |
| cc_pull | output | 2 | Current CC pull setting |
| irq | output | 1 | Interrupt, active high |

## Verification
Events, register writes and the initialization strobe take effect at the next clock edge. The alert register, the interrupt, ack_req and the CC status are therefore all settled by the following falling edge, and the bench samples them there. A register read returns its data one edge after the strobe. Each read pushes its expected value onto a queue, and a monitor pops that value on the falling edge where reg_rvalid is high, so every comparison lands on exactly the cycle the data is due. Reads are issued only in cycles with no concurrent event, so the value returned is the state left by the previous stimulus.

// File: rtl/pdc_alert_pkg.sv
package pdc_alert_pkg;
  typedef enum logic [1:0] {RXK_GOOD = 2'd0, RXK_HRST = 2'd1, RXK_BAD = 2'd2} rx_kind_e;
  typedef enum logic [1:0] {TXR_OK = 2'd0, TXR_NOACK = 2'd1, TXR_OTHER = 2'd2} tx_res_e;

  localparam int unsigned AB_CC     = 0;
  localparam int unsigned AB_PWR    = 1;
  localparam int unsigned AB_RXS    = 2;
  localparam int unsigned AB_RXHR   = 3;
  localparam int unsigned AB_TXFAIL = 4;
  localparam int unsigned AB_TXDISC = 5;
  localparam int unsigned AB_TXOK   = 6;

  localparam logic [4:0] A_ALERT  = 5'h00;
  localparam logic [4:0] A_AMASK  = 5'h01;
  localparam logic [4:0] A_PWR    = 5'h02;
  localparam logic [4:0] A_PMASK  = 5'h03;
  localparam logic [4:0] A_CCCTL  = 5'h04;
  localparam logic [4:0] A_CCSTAT = 5'h05;
  localparam logic [4:0] A_RXCNT  = 5'h06;
  localparam logic [4:0] A_RXHDR  = 5'h07;

  localparam int unsigned HDR_CNT_LSB = 12;
  localparam int unsigned HDR_ID_LSB  = 9;
  localparam logic [1:0]  CC_OPEN     = 2'd0;
endpackage

// File: rtl/pdc_rx_ring.sv
module pdc_rx_ring #(
  parameter int unsigned SLOTS   = 3,
  parameter int unsigned MAX_OBJ = 7,
  parameter int unsigned DW      = 32,
  parameter int unsigned HW      = 16,
  localparam int unsigned PW     = $clog2(SLOTS),
  localparam int unsigned IW     = $clog2(MAX_OBJ + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_word,
  input  logic          push,
  input  logic          pop,
  input  logic [HW-1:0] hdr_in,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [HW-1:0] tail_hdr,
  output logic [PW:0]   count
);
  localparam int unsigned DEPTH = 1 << (PW + IW);

  logic [PW-1:0] head_q, tail_q;
  logic [HW-1:0] hdr_mem [SLOTS];
  logic [DW-1:0] dmem [DEPTH];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (head_q >= tail_q) count = {1'b0, head_q} - {1'b0, tail_q};
    else                  count = (PW+1)'(SLOTS) + {1'b0, head_q} - {1'b0, tail_q};
  end

  logic full_w, empty_w;
  assign full_w  = (count == (PW+1)'(SLOTS - 1));
  assign empty_w = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < SLOTS; i++) hdr_mem[i] <= '0;
    end else begin
      if (push && !full_w) begin
        hdr_mem[head_q] <= hdr_in;
        head_q          <= nxt(head_q);
      end
      if (pop && !empty_w) tail_q <= nxt(tail_q);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) dmem[{head_q, wr_idx}] <= wr_word;
    rd_word <= dmem[{tail_q, rd_idx}];
  end

  assign tail_hdr = hdr_mem[tail_q];
endmodule

// File: rtl/pdc_alert_reg.sv
module pdc_alert_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] set_bits,
  input  logic [AW-1:0] clr_bits,
  input  logic          mask_wr,
  input  logic [AW-1:0] mask_val,
  output logic [AW-1:0] alert_q,
  output logic [AW-1:0] mask_q,
  output logic          irq_q
);
  logic [AW-1:0] alert_n, mask_n;
  logic          irq_n;

  always_comb begin
    alert_n = (alert_q & ~clr_bits) | set_bits;
    mask_n  = mask_wr ? mask_val : mask_q;
    if (alert_n == '0) irq_n = 1'b0;
    else               irq_n = irq_q | (|(set_bits & mask_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      alert_q <= alert_n;
      mask_q  <= mask_n;
      irq_q   <= irq_n;
    end
  end
endmodule

// File: rtl/pdc_cc_track.sv
module pdc_cc_track
  import pdc_alert_pkg::*;
#(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pull_wr,
  input  logic [CW-1:0] pull_val,
  input  logic          meas_vld,
  input  logic [CW-1:0] meas1,
  input  logic [CW-1:0] meas2,
  output logic [CW-1:0] pull_q,
  output logic [CW-1:0] st1_q,
  output logic [CW-1:0] st2_q,
  output logic          changed
);
  logic pull_change;
  assign pull_change = pull_wr && (pull_val != pull_q);
  assign changed     = !pull_change && meas_vld && ((meas1 != st1_q) || (meas2 != st2_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_q <= '0;
      st1_q  <= CW'(CC_OPEN);
      st2_q  <= CW'(CC_OPEN);
    end else if (pull_change) begin
      pull_q <= pull_val;
      st1_q  <= CW'(CC_OPEN);
      st2_q  <= CW'(CC_OPEN);
    end else if (meas_vld) begin
      st1_q <= meas1;
      st2_q <= meas2;
    end
  end
endmodule

// File: rtl/pdc_alert_core.sv
module pdc_alert_core
  import pdc_alert_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned RW      = 16,
  parameter int unsigned SLOTS   = 3,
  parameter int unsigned MAX_OBJ = 7,
  parameter int unsigned DW      = 32,
  parameter int unsigned PMW     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         init_go,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [RW-1:0]                reg_wdata,
  output logic [RW-1:0]                reg_rdata,
  output logic                         reg_rvalid,
  input  logic                         rx_word_we,
  input  logic [$clog2(MAX_OBJ+1)-1:0] rx_word_idx,
  input  logic [DW-1:0]                rx_word,
  input  logic                         rx_end,
  input  logic [1:0]                   rx_kind,
  input  logic [RW-1:0]                rx_hdr,
  output logic                         ack_req,
  output logic [2:0]                   ack_id,
  input  logic                         tx_done,
  input  logic [1:0]                   tx_res,
  input  logic                         cc_meas_vld,
  input  logic [1:0]                   cc1_meas,
  input  logic [1:0]                   cc2_meas,
  output logic [1:0]                   cc_pull,
  output logic                         irq
);
  localparam int unsigned IW = $clog2(MAX_OBJ + 1);
  localparam int unsigned PW = $clog2(SLOTS);
  localparam int unsigned HALF = DW / 2;

  logic          uninit_q;
  logic [PMW-1:0] pmask_q;
  logic          wr_ok;
  logic [RW-1:0] clr_raw, clr_eff, set_v, alert_q, mask_q;
  logic [PW:0]   rx_cnt;
  logic          rx_full, rx_empty, rx_push, rx_pop, rx_keep;
  logic [RW-1:0] tail_hdr;
  logic [DW-1:0] mem_word;
  logic [1:0]    cc_st1, cc_st2;
  logic          cc_chg;
  rx_kind_e      kind;
  tx_res_e       tres;

  assign kind  = rx_kind_e'(rx_kind);
  assign tres  = tx_res_e'(tx_res);
  assign wr_ok = reg_wr && !uninit_q;

  // init gate
  always_ff @(posedge clk) begin
    if (rst) begin
      uninit_q <= 1'b1;
      pmask_q  <= '0;
    end else begin
      if (init_go) begin
        uninit_q <= 1'b0;
        pmask_q  <= '1;
      end else if (wr_ok && reg_addr == ADDR_W'(A_PMASK)) begin
        pmask_q <= reg_wdata[PMW-1:0];
      end
    end
  end

  // receive store control
  assign rx_full  = (rx_cnt == (PW+1)'(SLOTS - 1));
  assign rx_empty = (rx_cnt == '0);
  assign rx_push  = rx_end && (kind == RXK_GOOD) && !rx_full;
  assign clr_raw  = (wr_ok && reg_addr == ADDR_W'(A_ALERT)) ? reg_wdata : '0;
  assign rx_pop   = clr_raw[AB_RXS] && !rx_empty;
  assign rx_keep  = rx_pop && (rx_cnt > (PW+1)'(1));

  always_comb begin
    clr_eff = clr_raw;
    if (rx_keep) clr_eff[AB_RXS] = 1'b0;
    set_v = '0;
    set_v[AB_CC]     = cc_chg;
    set_v[AB_PWR]    = init_go;
    set_v[AB_RXS]    = rx_push;
    set_v[AB_RXHR]   = rx_end && (kind == RXK_HRST);
    set_v[AB_TXOK]   = tx_done && (tres == TXR_OK);
    set_v[AB_TXFAIL] = tx_done && (tres == TXR_NOACK);
    set_v[AB_TXDISC] = tx_done && (tres != TXR_OK) && (tres != TXR_NOACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_req <= 1'b0;
      ack_id  <= '0;
    end else begin
      ack_req <= rx_push;
      if (rx_push) ack_id <= rx_hdr[HDR_ID_LSB +: 3];
    end
  end

  pdc_rx_ring #(.SLOTS(SLOTS), .MAX_OBJ(MAX_OBJ), .DW(DW), .HW(RW)) u_ring (
    .clk(clk), .rst(rst),
    .wr_en(rx_word_we), .wr_idx(rx_word_idx), .wr_word(rx_word),
    .push(rx_push), .pop(rx_pop), .hdr_in(rx_hdr),
    .rd_idx(reg_addr[IW:1]), .rd_word(mem_word),
    .tail_hdr(tail_hdr), .count(rx_cnt)
  );

  pdc_alert_reg #(.AW(RW)) u_alert (
    .clk(clk), .rst(rst),
    .set_bits(set_v), .clr_bits(clr_eff),
    .mask_wr(init_go || (wr_ok && reg_addr == ADDR_W'(A_AMASK))),
    .mask_val(init_go ? '1 : reg_wdata),
    .alert_q(alert_q), .mask_q(mask_q), .irq_q(irq)
  );

  pdc_cc_track #(.CW(2)) u_cc (
    .clk(clk), .rst(rst),
    .pull_wr(wr_ok && reg_addr == ADDR_W'(A_CCCTL)), .pull_val(reg_wdata[1:0]),
    .meas_vld(cc_meas_vld), .meas1(cc1_meas), .meas2(cc2_meas),
    .pull_q(cc_pull), .st1_q(cc_st1), .st2_q(cc_st2), .changed(cc_chg)
  );

  // register read path
  logic [RW-1:0] rd_mux, rd_q;
  logic          sel_mem_q, half_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_ALERT):  rd_mux = alert_q;
      ADDR_W'(A_AMASK):  rd_mux = mask_q;
      ADDR_W'(A_PWR):    rd_mux = RW'(uninit_q);
      ADDR_W'(A_PMASK):  rd_mux = RW'(pmask_q);
      ADDR_W'(A_CCCTL):  rd_mux = RW'(cc_pull);
      ADDR_W'(A_CCSTAT): rd_mux = RW'({cc_st2, cc_st1});
      ADDR_W'(A_RXCNT):  rd_mux = RW'(3 + 4 * tail_hdr[HDR_CNT_LSB +: 3]);
      ADDR_W'(A_RXHDR):  rd_mux = tail_hdr;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      rd_q       <= '0;
      sel_mem_q  <= 1'b0;
      half_q     <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        rd_q      <= rd_mux;
        sel_mem_q <= reg_addr[ADDR_W-1];
        half_q    <= reg_addr[0];
      end
    end
  end

  assign reg_rdata = !sel_mem_q ? rd_q : (half_q ? mem_word[DW-1:HALF] : mem_word[HALF-1:0]);
endmodule

// File: rtl/pdc_alert_chk.sv
module pdc_alert_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_rvalid,
  input logic              reg_wr,
  input logic              uninit,
  input logic [15:0]       mask,
  input logic [15:0]       alert,
  input logic              irq,
  input logic              rx_end,
  input logic [1:0]        rx_kind,
  input logic              rx_full,
  input logic              ack_req,
  input logic [1:0]        cc_pull,
  input logic [1:0]        cc_st1,
  input logic [1:0]        cc_st2
);
  p_irq_needs_alert_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (alert != 16'h0));

  p_drop_no_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_end && rx_kind == 2'd0 && rx_full) |=> !ack_req);

  p_hrst_alert_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_end && rx_kind == 2'd1) |=> alert[3]);

  p_gate_writes_r9: assert property (@(posedge clk) disable iff (rst)
    (uninit && reg_wr) |=> $stable(mask));

  p_cc_forced_open_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(cc_pull) |-> (cc_st1 == 2'd0 && cc_st2 == 2'd0));

  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
endmodule

bind pdc_alert_core pdc_alert_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .reg_wr(reg_wr),
  .uninit(uninit_q), .mask(mask_q), .alert(alert_q), .irq(irq),
  .rx_end(rx_end), .rx_kind(rx_kind), .rx_full(rx_full), .ack_req(ack_req),
  .cc_pull(cc_pull), .cc_st1(cc_st1), .cc_st2(cc_st2)
);

// File: tb/sim_pdc_alert_core.sv
`timescale 1ns/1ps
module sim_pdc_alert_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_go = 0, reg_wr = 0, reg_rd = 0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic        rx_word_we = 0;
  logic [2:0]  rx_word_idx = '0;
  logic [31:0] rx_word = '0;
  logic        rx_end = 0;
  logic [1:0]  rx_kind = '0;
  logic [15:0] rx_hdr = '0;
  logic        ack_req;
  logic [2:0]  ack_id;
  logic        tx_done = 0;
  logic [1:0]  tx_res = '0;
  logic        cc_meas_vld = 0;
  logic [1:0]  cc1_meas = '0, cc2_meas = '0;
  logic [1:0]  cc_pull;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pdc_alert_core u0 (.*);

  // monitor: pops expected read data when the design returns it
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read data %h expected none", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s read got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 0;
    @(negedge clk);
  endtask

  task automatic obj(input logic [2:0] i, input logic [31:0] w);
    rx_word_we = 1; rx_word_idx = i; rx_word = w;
    @(negedge clk);
    rx_word_we = 0;
  endtask

  task automatic rx_frame(input logic [1:0] k, input logic [15:0] h);
    rx_end = 1; rx_kind = k; rx_hdr = h;
    @(negedge clk);
    rx_end = 0;
  endtask

  task automatic tx(input logic [1:0] r);
    tx_done = 1; tx_res = r;
    @(negedge clk);
    tx_done = 0;
  endtask

  task automatic cc(input logic [1:0] a, input logic [1:0] b);
    cc_meas_vld = 1; cc1_meas = a; cc2_meas = b;
    @(negedge clk);
    cc_meas_vld = 0;
  endtask

  function automatic logic [15:0] mk_hdr(input int cnt, input int id);
    return {1'b0, 3'(cnt), 3'(id), 9'h003};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ha, hb, hc, hd;
    ha = mk_hdr(2, 3); hb = mk_hdr(1, 4); hc = mk_hdr(0, 5); hd = mk_hdr(3, 6);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state and init gate (R9, R1, R3)
    rd(5'h02, 16'h0001, "R9 uninit after reset");
    rd(5'h00, 16'h0000, "R1 alert reset");
    chk(16'(irq), 16'h0, "R3 irq reset");
    wr(5'h01, 16'hFFFF);
    rd(5'h01, 16'h0000, "R9 write ignored while uninit");
    init_go = 1; @(negedge clk); init_go = 0;
    chk(16'(irq), 16'h1, "R1 irq on power alert");
    rd(5'h02, 16'h0000, "R9 uninit cleared");
    rd(5'h01, 16'hFFFF, "R9 mask all ones");
    rd(5'h03, 16'h00FF, "R9 power mask all ones");
    rd(5'h00, 16'h0002, "R9 power alert");
    wr(5'h00, 16'h0002);
    chk(16'(irq), 16'h0, "R3 irq drops when alert zero");
    rd(5'h00, 16'h0000, "R2 cleared");

    // transmit outcomes, masking, exact clear (R1, R7, R2)
    wr(5'h01, 16'h0004);
    tx(2'd0);
    chk(16'(irq), 16'h0, "R1 masked event no irq");
    rd(5'h00, 16'h0040, "R7 success bit");
    tx(2'd1);
    tx(2'd3);
    rd(5'h00, 16'h0070, "R7 failed and discarded bits");
    wr(5'h00, 16'h0010);
    rd(5'h00, 16'h0060, "R2 only written bit cleared");
    wr(5'h00, 16'h0060);
    rd(5'h00, 16'h0000, "R2 all cleared");

    // receive store (R5, R8, R12)
    obj(3'd0, 32'hA0A0_0001);
    obj(3'd1, 32'hA0A0_0002);
    rx_frame(2'd0, ha);
    chk(16'(ack_req), 16'h1, "R5 ack first message");
    chk(16'(ack_id), 16'h3, "R5 ack id");
    chk(16'(irq), 16'h1, "R1 unmasked rx irq");
    rd(5'h00, 16'h0004, "R5 rx status alert");
    rd(5'h06, 16'd11, "R8 byte count");
    rd(5'h07, ha, "R8 header");
    rd(5'h10, 16'h0001, "R12 obj0 low");
    rd(5'h11, 16'hA0A0, "R12 obj0 high");
    rd(5'h12, 16'h0002, "R12 obj1 low");
    obj(3'd0, 32'hB0B0_0001);
    rx_frame(2'd0, hb);
    chk(16'(ack_req), 16'h1, "R5 ack second message");
    obj(3'd0, 32'hC0C0_0001);
    rx_frame(2'd0, hc);
    chk(16'(ack_req), 16'h0, "R5 full store no ack");
    rd(5'h07, ha, "R5 dropped message not stored");
    rx_frame(2'd1, 16'h0000);
    chk(16'(ack_req), 16'h0, "R6 hard reset no ack");
    rd(5'h00, 16'h000C, "R6 hard reset alert while full");

    // release (R4)
    wr(5'h00, 16'h0004);
    rd(5'h00, 16'h000C, "R4 rx status kept while nonempty");
    rd(5'h07, hb, "R4 next header");
    rd(5'h06, 16'd7, "R8 byte count second");
    rd(5'h10, 16'h0001, "R12 second obj0 low");
    rd(5'h11, 16'hB0B0, "R12 second obj0 high");
    wr(5'h00, 16'h0004);
    rd(5'h00, 16'h0008, "R4 rx status cleared when empty");
    chk(16'(irq), 16'h1, "R3 irq held by remaining bit");
    wr(5'h00, 16'h0008);
    chk(16'(irq), 16'h0, "R3 irq drops");

    // wrap of slots
    obj(3'd2, 32'hD0D0_0003);
    rx_frame(2'd0, hd);
    chk(16'(ack_id), 16'h6, "R5 ack id wrapped slot");
    rd(5'h06, 16'd15, "R8 byte count three objects");
    rd(5'h14, 16'h0003, "R12 wrapped obj2 low");
    rd(5'h15, 16'hD0D0, "R12 wrapped obj2 high");
    wr(5'h00, 16'h0004);
    rd(5'h00, 16'h0000, "R4 cleared after last");

    // CC tracking (R10)
    wr(5'h01, 16'h0001);
    cc(2'd2, 2'd1);
    chk(16'(irq), 16'h1, "R10 cc change irq");
    rd(5'h05, 16'h0006, "R10 cc status stored");
    rd(5'h00, 16'h0001, "R10 cc alert");
    wr(5'h00, 16'h0001);
    wr(5'h04, 16'h0001);
    rd(5'h05, 16'h0000, "R10 forced open");
    rd(5'h00, 16'h0000, "R10 no alert on pull change");
    rd(5'h04, 16'h0001, "R10 pull value");
    cc(2'd0, 2'd0);
    rd(5'h00, 16'h0000, "R10 same sample no alert");
    cc(2'd2, 2'd1);
    rd(5'h00, 16'h0001, "R10 later change alerts");
    wr(5'h00, 16'h0001);
    wr(5'h04, 16'h0001);
    rd(5'h05, 16'h0006, "R10 same pull no effect");

    // set wins over clear in the same cycle (R2)
    reg_wr = 1; reg_addr = 5'h00; reg_wdata = 16'h0040;
    tx_done = 1; tx_res = 2'd0;
    @(negedge clk);
    reg_wr = 0; tx_done = 0;
    rd(5'h00, 16'h0040, "R2 set wins over clear");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 %0d reads without data expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule